// File: doc/BRIEF.md
# Load/Store Memory Access Unit

This unit carries out the data-memory half of word and byte load/store instructions for a 32-bit RISC pipeline. Each request brings a decoded 6-bit operation code, the base register value, a 16-bit signed displacement, the store data register value and the index of the destination register. The unit forms the effective address and checks word accesses for alignment. It then drives a 32-bit, word-addressed synchronous data memory with one write enable per byte lane. For loads it returns the selected bytes, aligned and extended, to the register file together with the destination index.

Requests use a valid/ready handshake, and load results leave through a valid/ready response channel. The memory port and the alignment trap flag are plain signals. A memory read takes one cycle, so a load result appears the cycle after its request is accepted. If the consumer holds `rsp_ready` low, the result is captured internally and held stable. While a result is waiting, `req_ready` drops, so that no second read can overrun it. The parameter `BIG_ENDIAN` chooses how byte addresses map onto byte lanes.

Top module: `lsu_unit`

## Requirements
- R1: The effective address is `req_base` plus `req_off` sign-extended from bit 15 to 32 bits. An accepted legal access drives `mem_addr` with the effective address bits 31..2.
- R2: A word load or word store whose effective address has bits 1..0 other than 00 raises `exc_align` for exactly one cycle, the cycle after acceptance. It asserts neither `mem_en` nor any write enable, and it produces no load response.
- R3: Signed byte loads, unsigned byte loads and byte stores never raise `exc_align`, whatever the address.
- R4: A signed byte load returns the addressed byte in bits 7..0, with its bit 7 copied into bits 31..8.
- R5: An unsigned byte load returns the addressed byte in bits 7..0, with bits 31..8 cleared.
- R6: The lane is bits 1..0 of the effective address when `BIG_ENDIAN`=0, and 3 minus those bits when `BIG_ENDIAN`=1. Lane k is data bits 8k+7..8k. A byte store drives `req_wdata[7:0]` on all four lanes of `mem_wdata` and asserts only the write enable of the selected lane. Byte loads read from the same lane.
- R7: A word store asserts all four write enables. Word loads and word stores carry data lane for lane, so register bits 31..24 sit on lane 3. Seen at byte addresses, the least significant register byte goes to the lowest address when little-endian, and the most significant byte goes there when big-endian.
- R8: Operation codes: 100011 word load, 100000 signed byte load, 100100 unsigned byte load, 101011 word store, 101000 byte store. Any other code is accepted but gives no memory access, no write enable, no response and no exception.
- R9: `rsp_valid` rises the cycle after a legal load is accepted. It carries the result on `rsp_data` and the request's destination index on `rsp_rt`.
- R10: While `rsp_valid` is high and `rsp_ready` is low, `rsp_valid`, `rsp_data` and `rsp_rt` hold their values and `req_ready` is low. Otherwise `req_ready` is high.
- R11: During and straight after reset, `rsp_valid`, `exc_align` and `mem_en` are low, `mem_we` is zero and `req_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be accepted this cycle |
| req_op | input | 6 | Operation code |
| req_rt | input | 5 | Destination/data register index |
| req_base | input | 32 | Base register value |
| req_off | input | 16 | Signed displacement |
| req_wdata | input | 32 | Store data register value |
| mem_en | output | 1 | Memory access strobe |
| mem_we | output | 4 | Per-lane write enables |
| mem_addr | output | 30 | Memory word address |
| mem_wdata | output | 32 | Memory write data |
| mem_rdata | input | 32 | Memory read data, one cycle after `mem_en` |
| rsp_valid | output | 1 | Load result available |
| rsp_ready | input | 1 | Consumer takes the load result |
| rsp_data | output | 32 | Extended load result |
| rsp_rt | output | 5 | Destination register index of the result |
| exc_align | output | 1 | Misaligned word access trap, one-cycle pulse |

## Verification
The bench builds two copies of the unit side by side, one with `BIG_ENDIAN`=0 and one with `BIG_ENDIAN`=1, and drives both with the same stream of requests. Each copy has its own byte-addressed reference memory. Running both copies brings both lane maps within reach: byte stores followed by word loads of the same word show opposite byte orders, while address generation, the trap and extension behave the same in both. A phase that toggles `rsp_ready` at random exercises the capture path and the request stall.

// File: rtl/lsu_pkg.sv
package lsu_pkg;

  localparam int XLEN    = 32;
  localparam int OFF_W   = 16;
  localparam int OPC_W   = 6;
  localparam int REG_W   = 5;
  localparam int LANES   = XLEN / 8;
  localparam int LANE_W  = $clog2(LANES);
  localparam int WADDR_W = XLEN - LANE_W;

  localparam logic [OPC_W-1:0] OPC_LD_WORD  = 6'b100011;
  localparam logic [OPC_W-1:0] OPC_LD_BYTE  = 6'b100000;
  localparam logic [OPC_W-1:0] OPC_LD_UBYTE = 6'b100100;
  localparam logic [OPC_W-1:0] OPC_ST_WORD  = 6'b101011;
  localparam logic [OPC_W-1:0] OPC_ST_BYTE  = 6'b101000;

  typedef enum logic [2:0] {
    OP_NONE,
    OP_LW,
    OP_LB,
    OP_LBU,
    OP_SW,
    OP_SB
  } lsu_op_e;

  typedef struct packed {
    logic              word;
    logic              sign;
    logic [LANE_W-1:0] lane;
    logic [REG_W-1:0]  rt;
  } ld_meta_t;

  function automatic lsu_op_e decode_op(input logic [OPC_W-1:0] opc);
    lsu_op_e r;
    case (opc)
      OPC_LD_WORD:  r = OP_LW;
      OPC_LD_BYTE:  r = OP_LB;
      OPC_LD_UBYTE: r = OP_LBU;
      OPC_ST_WORD:  r = OP_SW;
      OPC_ST_BYTE:  r = OP_SB;
      default:      r = OP_NONE;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/lsu_agen.sv
module lsu_agen
  import lsu_pkg::*;
(
  input  logic [XLEN-1:0]    base_i,
  input  logic [OFF_W-1:0]   off_i,
  input  logic               word_i,
  output logic [WADDR_W-1:0] waddr_o,
  output logic [LANE_W-1:0]  boff_o,
  output logic               misalign_o
);
  localparam int SEXT_W = XLEN - OFF_W;

  logic [XLEN-1:0] off_ext;
  logic [XLEN-1:0] ea;

  assign off_ext    = {{SEXT_W{off_i[OFF_W-1]}}, off_i};
  assign ea         = base_i + off_ext;
  assign waddr_o    = ea[XLEN-1:LANE_W];
  assign boff_o     = ea[LANE_W-1:0];
  assign misalign_o = word_i && (ea[LANE_W-1:0] != '0);
endmodule

// File: rtl/lsu_lane_map.sv
module lsu_lane_map
  import lsu_pkg::*;
#(
  parameter bit BIG_ENDIAN = 1'b0
) (
  input  logic [LANE_W-1:0] boff_i,
  output logic [LANE_W-1:0] lane_o
);
  localparam logic [LANE_W-1:0] TOP_LANE = LANE_W'(LANES - 1);

  if (BIG_ENDIAN) begin : g_big
    assign lane_o = TOP_LANE - boff_i;
  end else begin : g_little
    assign lane_o = boff_i;
  end
endmodule

// File: rtl/lsu_store_steer.sv
module lsu_store_steer
  import lsu_pkg::*;
(
  input  logic              fire_i,
  input  logic              word_i,
  input  logic [LANE_W-1:0] lane_i,
  input  logic [XLEN-1:0]   data_i,
  output logic [LANES-1:0]  we_o,
  output logic [XLEN-1:0]   wdata_o
);
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign we_o[g]          = fire_i && (word_i || (lane_i == LANE_W'(g)));
    assign wdata_o[8*g +: 8] = word_i ? data_i[8*g +: 8] : data_i[7:0];
  end
endmodule

// File: rtl/lsu_load_extract.sv
module lsu_load_extract
  import lsu_pkg::*;
(
  input  logic [XLEN-1:0]   rdata_i,
  input  logic              word_i,
  input  logic              sign_i,
  input  logic [LANE_W-1:0] lane_i,
  output logic [XLEN-1:0]   data_o
);
  logic [7:0] lane_byte [LANES];
  logic [7:0] picked;

  for (genvar g = 0; g < LANES; g++) begin : g_split
    assign lane_byte[g] = rdata_i[8*g +: 8];
  end

  assign picked = lane_byte[lane_i];

  always_comb begin
    if (word_i) data_o = rdata_i;
    else        data_o = {{(XLEN-8){sign_i & picked[7]}}, picked};
  end
endmodule

// File: rtl/lsu_rsp_stage.sv
module lsu_rsp_stage
  import lsu_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             issue_i,
  input  ld_meta_t         meta_i,
  input  logic [XLEN-1:0]  rdata_i,
  input  logic             rsp_ready_i,
  output logic             rsp_valid_o,
  output logic [XLEN-1:0]  rsp_data_o,
  output logic [REG_W-1:0] rsp_rt_o,
  output logic             stall_o
);
  logic            pend_q;
  logic            hold_q;
  ld_meta_t        meta_q;
  logic [XLEN-1:0] hold_data_q;
  logic [XLEN-1:0] live_data;

  lsu_load_extract u_extract (
    .rdata_i (rdata_i),
    .word_i  (meta_q.word),
    .sign_i  (meta_q.sign),
    .lane_i  (meta_q.lane),
    .data_o  (live_data)
  );

  assign rsp_valid_o = pend_q | hold_q;
  assign rsp_data_o  = hold_q ? hold_data_q : live_data;
  assign rsp_rt_o    = meta_q.rt;
  assign stall_o     = rsp_valid_o & ~rsp_ready_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q      <= 1'b0;
      hold_q      <= 1'b0;
      meta_q      <= '0;
      hold_data_q <= '0;
    end else begin
      pend_q <= issue_i;
      if (issue_i) meta_q <= meta_i;
      if (pend_q && !rsp_ready_i) begin
        hold_q      <= 1'b1;
        hold_data_q <= live_data;
      end else if (hold_q && rsp_ready_i) begin
        hold_q <= 1'b0;
      end
    end
  end

  // R10: a waiting result keeps every field steady
  p_rsp_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid_o && !rsp_ready_i) |=>
      (rsp_valid_o && $stable(rsp_data_o) && $stable(rsp_rt_o)));

  // R9: an issued load is answered on the next cycle
  p_rsp_after_issue_r9: assert property (@(posedge clk) disable iff (!rst_n)
    issue_i |=> rsp_valid_o);
endmodule

// File: rtl/lsu_unit.sv
module lsu_unit
  import lsu_pkg::*;
#(
  parameter bit BIG_ENDIAN = 1'b0
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  output logic               req_ready,
  input  logic [OPC_W-1:0]   req_op,
  input  logic [REG_W-1:0]   req_rt,
  input  logic [XLEN-1:0]    req_base,
  input  logic [OFF_W-1:0]   req_off,
  input  logic [XLEN-1:0]    req_wdata,
  output logic               mem_en,
  output logic [LANES-1:0]   mem_we,
  output logic [WADDR_W-1:0] mem_addr,
  output logic [XLEN-1:0]    mem_wdata,
  input  logic [XLEN-1:0]    mem_rdata,
  output logic               rsp_valid,
  input  logic               rsp_ready,
  output logic [XLEN-1:0]    rsp_data,
  output logic [REG_W-1:0]   rsp_rt,
  output logic               exc_align
);
  lsu_op_e           op;
  logic              is_word, is_load, is_store, is_sign, legal;
  logic              misalign, fire, ok_fire, stall;
  logic              exc_q;
  logic [LANE_W-1:0] boff, lane;
  ld_meta_t          meta;

  assign op       = decode_op(req_op);
  assign legal    = (op != OP_NONE);
  assign is_word  = (op == OP_LW) || (op == OP_SW);
  assign is_load  = (op == OP_LW) || (op == OP_LB) || (op == OP_LBU);
  assign is_store = (op == OP_SW) || (op == OP_SB);
  assign is_sign  = (op == OP_LB);

  assign req_ready = ~stall;
  assign fire      = req_valid & req_ready;
  assign ok_fire   = fire & legal & ~misalign;
  assign mem_en    = ok_fire;

  lsu_agen u_agen (
    .base_i     (req_base),
    .off_i      (req_off),
    .word_i     (is_word),
    .waddr_o    (mem_addr),
    .boff_o     (boff),
    .misalign_o (misalign)
  );

  lsu_lane_map #(.BIG_ENDIAN(BIG_ENDIAN)) u_lane (
    .boff_i (boff),
    .lane_o (lane)
  );

  lsu_store_steer u_steer (
    .fire_i  (ok_fire & is_store),
    .word_i  (is_word),
    .lane_i  (lane),
    .data_i  (req_wdata),
    .we_o    (mem_we),
    .wdata_o (mem_wdata)
  );

  always_comb begin
    meta.word = is_word;
    meta.sign = is_sign;
    meta.lane = lane;
    meta.rt   = req_rt;
  end

  lsu_rsp_stage u_rsp (
    .clk         (clk),
    .rst_n       (rst_n),
    .issue_i     (ok_fire & is_load),
    .meta_i      (meta),
    .rdata_i     (mem_rdata),
    .rsp_ready_i (rsp_ready),
    .rsp_valid_o (rsp_valid),
    .rsp_data_o  (rsp_data),
    .rsp_rt_o    (rsp_rt),
    .stall_o     (stall)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) exc_q <= 1'b0;
    else        exc_q <= fire & misalign;
  end
  assign exc_align = exc_q;

  // R2: a misaligned word access writes nothing
  p_exc_no_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && misalign) |-> (mem_we == '0));

  // R2: the trap follows an accepted misaligned access
  p_exc_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && misalign) |=> exc_align);

  // R3: byte operations never trap
  p_byte_noexc_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && (op == OP_LB || op == OP_LBU || op == OP_SB)) |=> !exc_align);

  // R6: a byte store touches exactly one lane
  p_byte_one_lane_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_en && op == OP_SB) |-> ($countones(mem_we) == 1));

  // R8: unknown codes stay off the memory port
  p_unknown_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && op == OP_NONE) |-> (!mem_en && mem_we == '0));
endmodule

// File: tb/sim_lsu_unit.sv
module sim_lsu_unit;
  localparam int CLK_PERIOD = 10;
  localparam int NDUT       = 2;
  localparam int MW         = 64;
  localparam int WDOG       = 50000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic        req_valid = 1'b0;
  logic [5:0]  req_op    = '0;
  logic [4:0]  req_rt    = '0;
  logic [31:0] req_base  = '0;
  logic [15:0] req_off   = '0;
  logic [31:0] req_wdata = '0;
  logic        rsp_ready = 1'b1;

  logic [NDUT-1:0] req_ready, mem_en, rsp_valid, exc_align;
  logic [3:0]  mem_we    [NDUT];
  logic [29:0] mem_addr  [NDUT];
  logic [31:0] mem_wdata [NDUT];
  logic [31:0] mem_rdata [NDUT];
  logic [31:0] rsp_data  [NDUT];
  logic [4:0]  rsp_rt    [NDUT];

  lsu_unit #(.BIG_ENDIAN(1'b0)) u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready[0]),
    .req_op(req_op), .req_rt(req_rt), .req_base(req_base), .req_off(req_off),
    .req_wdata(req_wdata), .mem_en(mem_en[0]), .mem_we(mem_we[0]),
    .mem_addr(mem_addr[0]), .mem_wdata(mem_wdata[0]), .mem_rdata(mem_rdata[0]),
    .rsp_valid(rsp_valid[0]), .rsp_ready(rsp_ready), .rsp_data(rsp_data[0]),
    .rsp_rt(rsp_rt[0]), .exc_align(exc_align[0]));

  lsu_unit #(.BIG_ENDIAN(1'b1)) u1 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready[1]),
    .req_op(req_op), .req_rt(req_rt), .req_base(req_base), .req_off(req_off),
    .req_wdata(req_wdata), .mem_en(mem_en[1]), .mem_we(mem_we[1]),
    .mem_addr(mem_addr[1]), .mem_wdata(mem_wdata[1]), .mem_rdata(mem_rdata[1]),
    .rsp_valid(rsp_valid[1]), .rsp_ready(rsp_ready), .rsp_data(rsp_data[1]),
    .rsp_rt(rsp_rt[1]), .exc_align(exc_align[1]));

  // word RAM behind each copy, written only through the DUT port
  logic [31:0] phys [NDUT][MW];
  initial begin
    for (int d = 0; d < NDUT; d++)
      for (int w = 0; w < MW; w++) phys[d][w] = '0;
  end
  always @(posedge clk) begin
    for (int d = 0; d < NDUT; d++) begin
      if (mem_en[d]) begin
        mem_rdata[d] <= phys[d][mem_addr[d][5:0]];
        for (int k = 0; k < 4; k++)
          if (mem_we[d][k]) phys[d][mem_addr[d][5:0]][8*k +: 8] <= mem_wdata[d][8*k +: 8];
      end
    end
  end

  // reference model: byte-addressed memory and one expected-response slot per copy
  logic [7:0]  refb [NDUT][MW*4];
  logic        sv   [NDUT];
  logic [31:0] sd   [NDUT];
  logic [4:0]  srt  [NDUT];
  logic        xpend[NDUT];
  string       sreq [NDUT];

  int n_chk = 0;
  int n_err = 0;
  int cyc   = 0;
  bit stall_mode = 0;
  bit accepted;

  // per-cycle prediction, shared by both copies
  bit          p_fire, p_legal, p_mis, p_load, p_store, p_word, p_sign;
  logic [31:0] p_ea;
  string       p_tag;

  task automatic chk(input int d, input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s dut%0d %s actual=%h expected=%h", tag, d, what, act, exp);
    end
  endtask

  task automatic decode_req();
    p_legal = 1; p_load = 0; p_store = 0; p_word = 0; p_sign = 0;
    case (req_op)
      6'b100011: begin p_load = 1;  p_word = 1; p_tag = "R7"; end
      6'b100000: begin p_load = 1;  p_sign = 1; p_tag = "R4"; end
      6'b100100: begin p_load = 1;              p_tag = "R5"; end
      6'b101011: begin p_store = 1; p_word = 1; p_tag = "R7"; end
      6'b101000: begin p_store = 1;             p_tag = "R6"; end
      default:   begin p_legal = 0;             p_tag = "R8"; end
    endcase
    p_ea  = req_base + {{16{req_off[15]}}, req_off};
    p_mis = p_word && (p_ea[1:0] != 2'b00);
  endtask

  task automatic predict_and_check();
    bit exp_ready, exp_en;
    logic [3:0] exp_we;
    int lane;
    decode_req();
    exp_ready = !(sv[0] && !rsp_ready);
    p_fire = req_valid && exp_ready;
    accepted = p_fire;
    exp_en = p_fire && p_legal && !p_mis;
    for (int d = 0; d < NDUT; d++) begin
      chk(d, "R10", "req_ready", 32'(req_ready[d]), 32'(!(sv[d] && !rsp_ready)));
      chk(d, "R9", "rsp_valid", 32'(rsp_valid[d]), 32'(sv[d]));
      if (sv[d]) begin
        chk(d, sreq[d], "rsp_data", rsp_data[d], sd[d]);
        chk(d, "R9", "rsp_rt", 32'(rsp_rt[d]), 32'(srt[d]));
      end
      chk(d, "R2 R3", "exc_align", 32'(exc_align[d]), 32'(xpend[d]));
      chk(d, p_mis ? "R2" : (p_legal ? "R1" : "R8"), "mem_en", 32'(mem_en[d]), 32'(exp_en));
      if (exp_en) chk(d, "R1", "mem_addr", 32'(mem_addr[d]), 32'(p_ea[31:2]));
      lane = (d == 1) ? 3 - int'(p_ea[1:0]) : int'(p_ea[1:0]);
      exp_we = '0;
      if (exp_en && p_store) exp_we = p_word ? 4'hf : 4'(1 << lane);
      chk(d, p_mis ? "R2" : p_tag, "mem_we", 32'(mem_we[d]), 32'(exp_we));
      if (exp_en && p_store)
        chk(d, p_tag, "mem_wdata", mem_wdata[d],
            p_word ? req_wdata : {4{req_wdata[7:0]}});
    end
  endtask

  task automatic commit();
    int a;
    a = int'(p_ea[7:0]);
    for (int d = 0; d < NDUT; d++) begin
      if (sv[d] && rsp_ready) sv[d] = 0;
      xpend[d] = p_fire && p_mis;
      if (p_fire && p_legal && !p_mis) begin
        if (p_store) begin
          if (!p_word) refb[d][a] = req_wdata[7:0];
          else for (int k = 0; k < 4; k++)
            refb[d][a+k] = (d == 1) ? req_wdata[8*(3-k) +: 8] : req_wdata[8*k +: 8];
        end else begin
          sv[d] = 1; srt[d] = req_rt; sreq[d] = p_tag;
          if (p_word)
            sd[d] = (d == 1) ? {refb[d][a], refb[d][a+1], refb[d][a+2], refb[d][a+3]}
                             : {refb[d][a+3], refb[d][a+2], refb[d][a+1], refb[d][a]};
          else
            sd[d] = {{24{p_sign & refb[d][a][7]}}, refb[d][a]};
        end
      end
    end
  endtask

  task automatic tick();
    #1;
    predict_and_check();
    @(posedge clk);
    commit();
    @(negedge clk);
    if (stall_mode) rsp_ready = ($urandom_range(0, 2) != 0);
    else            rsp_ready = 1'b1;
  endtask

  task automatic do_op(input logic [5:0] o, input logic [4:0] rt, input logic [31:0] b,
                       input logic [15:0] f, input logic [31:0] w);
    req_valid = 1; req_op = o; req_rt = rt; req_base = b; req_off = f; req_wdata = w;
    accepted = 0;
    while (!accepted) tick();
    req_valid = 0;
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > WDOG) begin
      n_err++;
      $display("FAIL R9 watchdog: cycles=%0d expected below %0d", cyc, WDOG);
      summary();
      $finish;
    end
  end

  localparam logic [5:0] LW = 6'b100011, LB = 6'b100000, LBU = 6'b100100;
  localparam logic [5:0] SW = 6'b101011, SB = 6'b101000;

  initial begin
    for (int d = 0; d < NDUT; d++) begin
      sv[d] = 0; sd[d] = '0; srt[d] = '0; xpend[d] = 0; sreq[d] = "R9";
      for (int i = 0; i < MW*4; i++) refb[d][i] = '0;
    end
    // R11: reset state
    repeat (3) @(negedge clk);
    for (int d = 0; d < NDUT; d++) begin
      chk(d, "R11", "req_ready", 32'(req_ready[d]), 32'd1);
      chk(d, "R11", "rsp_valid", 32'(rsp_valid[d]), 32'd0);
      chk(d, "R11", "exc_align", 32'(exc_align[d]), 32'd0);
      chk(d, "R11", "mem_en",    32'(mem_en[d]),    32'd0);
      chk(d, "R11", "mem_we",    32'(mem_we[d]),    32'd0);
    end
    rst_n = 1'b1;
    tick();

    // R1: negative displacement, then read back through a positive one
    do_op(SW, 5'd3, 32'h0000_0100, 16'hFFF0, 32'h1122_3344);
    do_op(LW, 5'd4, 32'h0000_00E0, 16'h0010, 32'h0);
    // R6: byte stores into every lane, then a word load shows the byte order (R7)
    do_op(SB, 5'd1, 32'h0000_0040, 16'h0000, 32'hDEAD_BEA1);
    do_op(SB, 5'd1, 32'h0000_0040, 16'h0001, 32'hDEAD_BE82);
    do_op(SB, 5'd1, 32'h0000_0040, 16'h0002, 32'hDEAD_BE73);
    do_op(SB, 5'd1, 32'h0000_0040, 16'h0003, 32'hDEAD_BEF4);
    do_op(LW, 5'd7, 32'h0000_0040, 16'h0000, 32'h0);
    // R4, R5: sign and zero extension
    do_op(LB,  5'd8, 32'h0000_0041, 16'h0000, 32'h0);
    do_op(LBU, 5'd9, 32'h0000_0041, 16'h0000, 32'h0);
    do_op(LB,  5'd10, 32'h0000_0042, 16'h0000, 32'h0);
    // R2: misaligned word accesses, memory must be unchanged afterwards
    do_op(LW, 5'd11, 32'h0000_0040, 16'h0002, 32'h0);
    do_op(SW, 5'd12, 32'h0000_0041, 16'h0000, 32'hFFFF_FFFF);
    do_op(LW, 5'd13, 32'h0000_0040, 16'h0000, 32'h0);
    // R3: byte load at an odd address
    do_op(LB, 5'd14, 32'h0000_0043, 16'h0000, 32'h0);
    // R8: unknown codes leave memory alone
    do_op(6'b100001, 5'd15, 32'h0000_0040, 16'h0, 32'h0);
    do_op(6'b000000, 5'd16, 32'h0000_0040, 16'h0, 32'hFFFF_FFFF);
    do_op(6'b101001, 5'd17, 32'h0000_0040, 16'h0, 32'hFFFF_FFFF);
    do_op(LW, 5'd18, 32'h0000_0040, 16'h0000, 32'h0);
    tick();

    // R10: back-pressure with random traffic
    stall_mode = 1;
    for (int i = 0; i < 600; i++) begin
      logic [5:0]  o;
      logic [31:0] b;
      logic [15:0] f;
      case ($urandom_range(0, 7))
        0: o = LW; 1: o = LB; 2: o = LBU; 3: o = SW; 4: o = SB;
        5: o = 6'b100001; 6: o = LW; default: o = SB;
      endcase
      b = $urandom; f = 16'($urandom);
      if ($urandom_range(0, 1) == 1) begin b[1:0] = 2'b00; f[1:0] = 2'b00; end
      do_op(o, 5'($urandom), b, f, $urandom);
      if ($urandom_range(0, 3) == 0) tick();
    end
    stall_mode = 0;
    repeat (4) tick();

    summary();
    $finish;
  end
endmodule